// File: doc/BRIEF.md
# Framed Serial Register Access Port

This block is the control port of a chip that acts as master of its own serial link. It generates the serial clock from the master clock through a programmable divider. It takes in 16-bit framed words that write a small register set or select a register to be read back. A framed 16-bit reply then carries the chosen register's contents back out. Each word has a 10-bit data field followed by a 6-bit address field, and the most significant bit goes first in both directions.

The host drives input data and an input frame sync, and the block samples both on the falling edge of the serial clock. To read a register, the host writes the register's address into a read-select register. After a short fixed wait the block returns the value with an output frame sync, and its outputs change on rising serial-clock edges. A port-enable input takes the whole port off the bus. A self-clearing soft-reset bit clears the general registers but leaves the clock rate and the read selection alone.

Top module: `sctl_port`

## Requirements
- R1: After hardware reset the rate register holds 4, so the serial clock period is 8 master cycles. The control register and the general registers read 0, `sdo_oe` is 0 and `sfs` is 0.
- R2: For a rate value N of 1 or more, the serial clock period is 2*N master cycles. A rate of 0 behaves like 1, which gives a period of 2 master cycles.
- R3: `sdi` and `sdi_fs` are sampled on each falling serial-clock edge. The sample with `sdi_fs` high carries word bit 15, and the next 15 samples carry bits 14 down to 0. Bits 15:6 are data and bits 5:0 are the address. A completed word writes the rate register at 0x01, the control register at 0x03, or general register k at 0x08+k. General register k appears at `cfg_regs[k*10 +: 10]`.
- R4: Address 0x04 is read-only and returns the ID_VAL parameter. A write to 0x04 or to any unmapped address changes no register, and an unmapped address reads 0.
- R5: A write to address 0x02 loads the read-select register from word bits 11:6, ignores bits 15:12, and requests a reply. Reading 0x02 returns the read selection zero-extended.
- R6: A reply is 16 bits sent MSB first. Bits 15:6 hold the selected register's value at launch and bits 5:0 hold its address. `sfs` is high only during the first bit, and `sdo_oe` is high for exactly the 16 bit periods. The outputs change on rising serial-clock edges.
- R7: `sfs` of a reply rises at the first rising serial-clock edge that comes at least 4 master cycles after the read-select register is updated.
- R8: If `sdi_fs` is sampled high while fewer than 16 samples of the current word have been taken, the word in progress and the new one are both discarded.
- R9: Writing 0x03 with data bit 0 set starts a soft reset. The control register and the general registers are cleared, and control bit 0 reads 1 for 4 master cycles and then clears itself. The rate and read-select registers keep their values.
- R10: While `port_en` is low, `sclk_oe`, `sdo_oe` and `sfs_oe` are 0, and frames presented on `sdi`/`sdi_fs` are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Hardware reset, active low |
| port_en | input | 1 | Port enable; low releases all port outputs |
| sdi | input | 1 | Serial data in |
| sdi_fs | input | 1 | Input frame sync, marks bit 15 |
| sclk | output | 1 | Generated serial clock |
| sclk_oe | output | 1 | Drive enable for sclk |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo, high only while a reply is sent |
| sfs | output | 1 | Output frame sync, marks reply bit 15 |
| sfs_oe | output | 1 | Drive enable for sfs |
| cfg_regs | output | 40 | General registers, register k at bits k*10+9:k*10 |

## Verification
The link is full duplex, so an incoming word can still be shifting in while a reply is shifting out. The bench provokes this by sending a write to the same register straight after the read request for that register. The write then completes while the reply is still in flight. The bench checks that the reply carries the value held at launch, and that the register takes the new value once the write word ends. The reply wait is also measured at two clock rates, because launch has to fall on a rising serial edge after the 4-cycle wait.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
    localparam int DW    = 10;
    localparam int AW    = 6;
    localparam int WW    = DW + AW;
    localparam int RATEW = 10;
    localparam int BITW  = $clog2(WW);

    localparam int SRST_CYC = 4;
    localparam int RD_LAT   = 4;
    localparam int SRSTW    = $clog2(SRST_CYC + 1);
    localparam int WAITW    = $clog2(RD_LAT + 1);

    localparam logic [AW-1:0]    ADDR_RATE  = 6'h01;
    localparam logic [AW-1:0]    ADDR_RDSEL = 6'h02;
    localparam logic [AW-1:0]    ADDR_CTRL  = 6'h03;
    localparam logic [AW-1:0]    ADDR_ID    = 6'h04;
    localparam logic [AW-1:0]    ADDR_GEN0  = 6'h08;
    localparam logic [RATEW-1:0] RATE_RST   = 10'd4;
endpackage

// File: rtl/sctl_clkgen.sv
module sctl_clkgen
    import sctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RATEW-1:0] rate,
    output logic             sclk,
    output logic             rise_evt,
    output logic             fall_evt
);
    typedef struct packed {
        logic [RATEW-1:0] cnt;
        logic             sclk;
    } st_t;

    st_t              s_d, s_q;
    logic [RATEW-1:0] half_m1;

    always_comb begin
        half_m1  = (rate == '0) ? '0 : rate - 1'b1;
        s_d      = s_q;
        rise_evt = 1'b0;
        fall_evt = 1'b0;
        if (s_q.cnt >= half_m1) begin
            s_d.cnt  = '0;
            s_d.sclk = ~s_q.sclk;
            rise_evt = ~s_q.sclk;
            fall_evt = s_q.sclk;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk = s_q.sclk;

    // R2: with the rate held at 0 or 1 the serial clock toggles every master cycle
    assert_fast_toggle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rate <= 10'd1 && $past(rate) <= 10'd1) |-> (sclk != $past(sclk)));
endmodule

// File: rtl/sctl_rx.sv
module sctl_rx
    import sctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          fall_evt,
    input  logic          sdi,
    input  logic          sdi_fs,
    output logic          word_vld,
    output logic [WW-1:0] word
);
    typedef struct packed {
        logic            busy;
        logic [BITW-1:0] cnt;
        logic [WW-1:0]   sh;
        logic            vld;
        logic [WW-1:0]   word;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.vld = 1'b0;
        if (!en) begin
            s_d.busy = 1'b0;
        end else if (fall_evt) begin
            if (sdi_fs) begin
                if (s_q.busy) begin
                    s_d.busy = 1'b0;              // R8: frame sync too early, drop both
                end else begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = BITW'(1);
                    s_d.sh   = {{(WW-1){1'b0}}, sdi};
                end
            end else if (s_q.busy) begin
                s_d.sh = {s_q.sh[WW-2:0], sdi};
                if (s_q.cnt == BITW'(WW-1)) begin
                    s_d.busy = 1'b0;
                    s_d.vld  = 1'b1;
                    s_d.word = {s_q.sh[WW-2:0], sdi};
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign word_vld = s_q.vld;
    assign word     = s_q.word;

    // R3: a completed word only follows a falling serial-clock sample
    assert_vld_after_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_vld |-> $past(fall_evt && en));
    // R8: a frame sync that lands inside a word never yields a word
    assert_early_fs_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_evt && en && sdi_fs && s_q.busy) |=> !word_vld);
endmodule

// File: rtl/sctl_regs.sv
module sctl_regs
    import sctl_pkg::*;
#(
    parameter int          NGEN   = 4,
    parameter logic [9:0]  ID_VAL = 10'h2A5
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_vld,
    input  logic [WW-1:0]      wr_word,
    output logic [RATEW-1:0]   rate,
    output logic [AW-1:0]      rd_addr,
    output logic [DW-1:0]      rd_data,
    output logic               rd_req,
    output logic [NGEN*DW-1:0] gen_flat
);
    typedef struct packed {
        logic [NGEN-1:0][DW-1:0] gen;
        logic [RATEW-1:0]        rate;
        logic [AW-1:0]           rdsel;
        logic [DW-1:0]           ctrl;
        logic [SRSTW-1:0]        srst;
    } st_t;

    st_t             s_d, s_q;
    logic [AW-1:0]   wr_addr;
    logic [DW-1:0]   wr_data;
    logic [NGEN-1:0] wr_hit;
    logic [NGEN-1:0] rd_hit;
    logic            writable;

    assign wr_addr = wr_word[AW-1:0];
    assign wr_data = wr_word[WW-1:AW];

    for (genvar g = 0; g < NGEN; g++) begin : g_dec
        assign wr_hit[g] = (wr_addr == ADDR_GEN0 + AW'(g));
        assign rd_hit[g] = (s_q.rdsel == ADDR_GEN0 + AW'(g));
    end

    assign writable = (wr_addr == ADDR_RATE) || (wr_addr == ADDR_RDSEL) ||
                      (wr_addr == ADDR_CTRL) || (|wr_hit);

    always_comb begin
        s_d    = s_q;
        rd_req = 1'b0;
        if (s_q.srst != '0) begin
            s_d.srst = s_q.srst - 1'b1;
            s_d.gen  = '0;
            s_d.ctrl = (s_q.srst == SRSTW'(1)) ? '0 : DW'(1);
        end else if (wr_vld) begin
            if (wr_addr == ADDR_RATE) s_d.rate = wr_data;
            if (wr_addr == ADDR_RDSEL) begin
                s_d.rdsel = wr_word[2*AW-1:AW];
                rd_req    = 1'b1;
            end
            if (wr_addr == ADDR_CTRL) begin
                if (wr_data[0]) begin
                    s_d.srst = SRSTW'(SRST_CYC);
                    s_d.ctrl = DW'(1);
                    s_d.gen  = '0;
                end else begin
                    s_d.ctrl = wr_data;
                end
            end
            for (int k = 0; k < NGEN; k++) begin
                if (wr_hit[k]) s_d.gen[k] = wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        if (s_q.rdsel == ADDR_RATE)  rd_data = s_q.rate;
        if (s_q.rdsel == ADDR_RDSEL) rd_data = DW'(s_q.rdsel);
        if (s_q.rdsel == ADDR_CTRL)  rd_data = s_q.ctrl;
        if (s_q.rdsel == ADDR_ID)    rd_data = ID_VAL;
        for (int k = 0; k < NGEN; k++) begin
            if (rd_hit[k]) rd_data = s_q.gen[k];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.rate <= RATE_RST;
        end else begin
            s_q <= s_d;
        end
    end

    assign rate     = s_q.rate;
    assign rd_addr  = s_q.rdsel;
    assign gen_flat = s_q.gen;

    // R9: the self-clearing bit stays high for exactly four master cycles
    assert_srst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ctrl[0]) |-> s_q.ctrl[0] ##1 s_q.ctrl[0] ##1 s_q.ctrl[0]
                               ##1 s_q.ctrl[0] ##1 !s_q.ctrl[0]);
    // R9: soft reset leaves clock rate and read selection alone
    assert_srst_keeps_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.srst != '0) |=> ($stable(s_q.rate) && $stable(s_q.rdsel)));
    // R4: a write to a read-only or unmapped address leaves every register as it was
    assert_ignore_ro_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !writable && s_q.srst == '0) |=> $stable(s_q));
endmodule

// File: rtl/sctl_tx.sv
module sctl_tx
    import sctl_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise_evt,
    input  logic          rd_req,
    input  logic [DW-1:0] rd_data,
    input  logic [AW-1:0] rd_addr,
    output logic          sdo,
    output logic          sdo_act,
    output logic          sfs
);
    typedef struct packed {
        logic             pend;
        logic [WAITW-1:0] wt;
        logic             busy;
        logic [BITW-1:0]  cnt;
        logic [WW-1:0]    sh;
        logic             sdo;
        logic             act;
        logic             fs;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (s_q.wt != '0) s_d.wt = s_q.wt - 1'b1;
        if (rise_evt) begin
            if (s_q.busy && s_q.cnt != BITW'(WW-1)) begin
                s_d.cnt = s_q.cnt + 1'b1;
                s_d.sh  = {s_q.sh[WW-2:0], 1'b0};
                s_d.sdo = s_q.sh[WW-2];
                s_d.fs  = 1'b0;
            end else if (s_q.pend && s_q.wt == '0) begin
                s_d.busy = 1'b1;
                s_d.cnt  = '0;
                s_d.sh   = {rd_data, rd_addr};
                s_d.sdo  = rd_data[DW-1];
                s_d.fs   = 1'b1;
                s_d.act  = 1'b1;
                s_d.pend = 1'b0;
            end else begin
                s_d.busy = 1'b0;
                s_d.act  = 1'b0;
                s_d.sdo  = 1'b0;
                s_d.fs   = 1'b0;
            end
        end
        if (rd_req) begin
            s_d.pend = 1'b1;
            s_d.wt   = WAITW'(RD_LAT - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sdo     = s_q.sdo;
    assign sdo_act = s_q.act;
    assign sfs     = s_q.fs;

    // checker: master cycles since the last read request, saturating
    logic [2:0] since_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_q <= 3'd7;
        else if (rd_req)         since_q <= 3'd1;
        else if (since_q != 3'd7) since_q <= since_q + 3'd1;
    end

    // R6: frame sync only while data is driven, and every reply opens with it
    assert_fs_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
        sfs |-> sdo_act);
    assert_start_with_fs_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdo_act) |-> sfs);
    // R7: a reply never starts within four master cycles of its request
    assert_reply_wait_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sfs) |-> ($past(since_q) >= 3'(RD_LAT)));
endmodule

// File: rtl/sctl_port.sv
module sctl_port
    import sctl_pkg::*;
#(
    parameter int         NGEN   = 4,
    parameter logic [9:0] ID_VAL = 10'h2A5
)(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               port_en,
    input  logic               sdi,
    input  logic               sdi_fs,
    output logic               sclk,
    output logic               sclk_oe,
    output logic               sdo,
    output logic               sdo_oe,
    output logic               sfs,
    output logic               sfs_oe,
    output logic [NGEN*DW-1:0] cfg_regs
);
    logic             rise_evt, fall_evt;
    logic [RATEW-1:0] rate;
    logic             word_vld;
    logic [WW-1:0]    word;
    logic [AW-1:0]    rd_addr;
    logic [DW-1:0]    rd_data;
    logic             rd_req;
    logic             tx_sdo, tx_act;

    sctl_clkgen u_clk (
        .clk(clk), .rst_n(rst_n), .rate(rate),
        .sclk(sclk), .rise_evt(rise_evt), .fall_evt(fall_evt)
    );

    sctl_rx u_rx (
        .clk(clk), .rst_n(rst_n), .en(port_en), .fall_evt(fall_evt),
        .sdi(sdi), .sdi_fs(sdi_fs), .word_vld(word_vld), .word(word)
    );

    sctl_regs #(.NGEN(NGEN), .ID_VAL(ID_VAL)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_vld(word_vld), .wr_word(word),
        .rate(rate), .rd_addr(rd_addr), .rd_data(rd_data),
        .rd_req(rd_req), .gen_flat(cfg_regs)
    );

    sctl_tx u_tx (
        .clk(clk), .rst_n(rst_n), .rise_evt(rise_evt), .rd_req(rd_req),
        .rd_data(rd_data), .rd_addr(rd_addr),
        .sdo(tx_sdo), .sdo_act(tx_act), .sfs(sfs)
    );

    assign sclk_oe = port_en;
    assign sfs_oe  = port_en;
    assign sdo_oe  = tx_act & port_en;
    assign sdo     = tx_sdo & port_en;
endmodule

// File: tb/sctl_port_tb_top.sv
`timescale 1ns/1ps
module sctl_port_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        port_en = 1'b1;
    logic        sdi = 1'b0;
    logic        sdi_fs = 1'b0;
    logic        sclk, sclk_oe, sdo, sdo_oe, sfs, sfs_oe;
    logic [39:0] cfg_regs;

    int  n_chk = 0;
    int  n_bad = 0;
    bit  finished = 0;
    real t_last, t_fs;
    logic [9:0] exp_gen [4];

    always #2.5 clk = ~clk;

    sctl_port dut_i (
        .clk(clk), .rst_n(rst_n), .port_en(port_en), .sdi(sdi), .sdi_fs(sdi_fs),
        .sclk(sclk), .sclk_oe(sclk_oe), .sdo(sdo), .sdo_oe(sdo_oe),
        .sfs(sfs), .sfs_oe(sfs_oe), .cfg_regs(cfg_regs)
    );

    localparam int NV = 8;
    localparam logic [5:0] V_ADDR [NV] = '{6'h08, 6'h09, 6'h0A, 6'h0B, 6'h04, 6'h20, 6'h03, 6'h0C};
    localparam logic [9:0] V_DATA [NV] = '{10'h155, 10'h2AA, 10'h3FF, 10'h001, 10'h0F0, 10'h123, 10'h3F6, 10'h111};
    localparam logic [9:0] V_EXP  [NV] = '{10'h155, 10'h2AA, 10'h3FF, 10'h001, 10'h2A5, 10'h000, 10'h3F6, 10'h000};

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_word(input logic [15:0] w);
        @(posedge sclk); #1;
        sdi_fs = 1'b1; sdi = w[15];
        for (int i = 14; i >= 0; i--) begin
            @(posedge sclk); #1;
            sdi_fs = 1'b0; sdi = w[i];
        end
        @(negedge sclk); t_last = $realtime;
        @(posedge sclk); #1;
        sdi = 1'b0;
    endtask

    task automatic capture(output logic [15:0] w, output bit good);
        good = 1'b1; w = '0;
        @(posedge sfs); t_fs = $realtime;
        for (int i = 15; i >= 0; i--) begin
            @(negedge sclk);
            w[i] = sdo;
            if (!sdo_oe) good = 1'b0;
            if ((i == 15) != (sfs == 1'b1)) good = 1'b0;
        end
        @(negedge sclk);
        if (sdo_oe) good = 1'b0;
    endtask

    task automatic wr(input logic [5:0] a, input logic [9:0] d);
        send_word({d, a});
        repeat (4) @(posedge clk);
    endtask

    task automatic rd(input logic [5:0] a, output logic [15:0] w, output bit good);
        fork
            send_word({4'h0, a, 6'h02});
            capture(w, good);
        join
        repeat (2) @(posedge clk);
    endtask

    task automatic period(output int p);
        real t0;
        @(posedge sclk); @(posedge sclk); t0 = $realtime;
        @(posedge sclk); p = int'($realtime - t0);
    endtask

    function automatic logic [39:0] exp_cfg();
        return {exp_gen[3], exp_gen[2], exp_gen[1], exp_gen[0]};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        bit g;
        int p;
        for (int k = 0; k < 4; k++) exp_gen[k] = '0;

        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk); #1;

        // R1 reset state
        chk(sdo_oe == 1'b0 && sfs == 1'b0, "R1 idle outputs", {sdo_oe, sfs}, 0);
        chk(cfg_regs == '0, "R1 general regs zero", cfg_regs, 0);
        chk(sclk_oe && sfs_oe, "R10 enabled drives", {sclk_oe, sfs_oe}, 2'b11);
        period(p);
        chk(p == 40, "R1 reset clock period", p, 40);
        rd(6'h01, w, g);
        chk(w == {10'd4, 6'h01} && g, "R1 rate reads 4", w, {10'd4, 6'h01});
        chk(int'(t_fs - t_last) == 60, "R7 reply wait at rate 4", int'(t_fs - t_last), 60);
        rd(6'h03, w, g);
        chk(w == {10'd0, 6'h03} && g, "R1 control reads 0", w, {10'd0, 6'h03});

        // R3 R4 R6 table walk: write then read back
        for (int v = 0; v < NV; v++) begin
            wr(V_ADDR[v], V_DATA[v]);
            if (V_ADDR[v] >= 6'h08 && V_ADDR[v] < 6'h0C) exp_gen[V_ADDR[v] - 6'h08] = V_DATA[v];
            rd(V_ADDR[v], w, g);
            chk(w == {V_EXP[v], V_ADDR[v]}, "R3/R4 table readback", w, {V_EXP[v], V_ADDR[v]});
            chk(g, "R6 reply framing", g, 1);
        end
        chk(cfg_regs == exp_cfg(), "R3 cfg_regs layout", cfg_regs, exp_cfg());

        // R5 upper don't-care bits ignored, readback of the read-select register
        fork
            send_word({4'hF, 6'h02, 6'h02});
            capture(w, g);
        join
        chk(w == {10'h002, 6'h02} && g, "R5 read-select readback", w, {10'h002, 6'h02});

        // R2 rate variants, R7 at rate 1
        wr(6'h01, 10'd1);
        period(p);
        chk(p == 10, "R2 rate 1 period", p, 10);
        rd(6'h09, w, g);
        chk(w == {10'h2AA, 6'h09} && g, "R2 readback at rate 1", w, {10'h2AA, 6'h09});
        chk(int'(t_fs - t_last) == 25, "R7 reply wait at rate 1", int'(t_fs - t_last), 25);
        wr(6'h01, 10'd0);
        period(p);
        chk(p == 10, "R2 rate 0 period", p, 10);
        wr(6'h01, 10'd2);
        period(p);
        chk(p == 20, "R2 rate 2 period", p, 20);
        wr(6'h01, 10'd4);
        period(p);
        chk(p == 40, "R2 rate 4 period", p, 40);

        // R8 early frame sync drops both words
        @(posedge sclk); #1;
        sdi_fs = 1'b1; sdi = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(posedge sclk); #1;
            sdi_fs = 1'b0; sdi = 1'b1;
        end
        send_word({10'h0AB, 6'h08});
        repeat (4) @(posedge clk);
        chk(cfg_regs == exp_cfg(), "R8 overlapped frames dropped", cfg_regs, exp_cfg());
        wr(6'h08, 10'h0CD);
        exp_gen[0] = 10'h0CD;
        chk(cfg_regs == exp_cfg(), "R8 clean frame after error", cfg_regs, exp_cfg());

        // R10 port disabled
        port_en = 1'b0; #1;
        chk(!sclk_oe && !sdo_oe && !sfs_oe, "R10 outputs released", {sclk_oe, sdo_oe, sfs_oe}, 0);
        wr(6'h09, 10'h077);
        chk(cfg_regs == exp_cfg(), "R10 frame ignored when disabled", cfg_regs, exp_cfg());
        port_en = 1'b1;

        // R6 full duplex: write lands while the reply of the same register shifts out
        fork
            begin
                send_word({4'h0, 6'h0A, 6'h02});
                send_word({10'h100, 6'h0A});
            end
            capture(w, g);
        join
        repeat (4) @(posedge clk);
        exp_gen[2] = 10'h100;
        chk(w == {10'h3FF, 6'h0A} && g, "R6 reply holds value at launch", w, {10'h3FF, 6'h0A});
        chk(cfg_regs == exp_cfg(), "R6 concurrent write applied", cfg_regs, exp_cfg());

        // R9 soft reset
        wr(6'h03, 10'h001);
        repeat (8) @(posedge clk);
        for (int k = 0; k < 4; k++) exp_gen[k] = '0;
        chk(cfg_regs == '0, "R9 general regs cleared", cfg_regs, 0);
        period(p);
        chk(p == 40, "R9 rate kept", p, 40);
        rd(6'h03, w, g);
        chk(w == {10'h000, 6'h03} && g, "R9 control self-cleared", w, {10'h000, 6'h03});
        rd(6'h01, w, g);
        chk(w == {10'd4, 6'h01} && g, "R9 rate register kept", w, {10'd4, 6'h01});

        finished = 1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule